// File: doc/BRIEF.md
# Chunked SPI Transfer Engine with Busy-Word Polling

This block is a host-side SPI master. It takes one request at a time, with a byte address, a byte length, a direction and a fixed-address flag, and turns it into a sequence of bus transactions. The request is cut into chunks of at most `MAX_CHUNK` bytes. Every chunk opens with a 32-bit command word that carries the direction, the fixed flag, the chunk length and the chunk address. Write data follows the command at once. For a read, the engine first collects a block of busy words from the target. If the last of them does not signal ready, the engine polls one word at a time, up to a bounded number of attempts, before it accepts data.

Payload moves as whole 32-bit words over two ready/valid streams, one for each direction. A chunk whose byte length is not a multiple of four still moves whole words on the wire. A single-cycle `done` marks the end of a request. `err` rises together with `done` when a read gave up because the poll limit ran out. In that case the chunk in flight is delivered as zero words and the rest of the request is dropped. Bits go out most significant first in SPI mode 0, with one serial bit every two clock cycles.

Top module: `spi_chunk_engine`

## Requirements
- R1: Each chunk starts with one command word, sent most significant bit first: bit 31 = 0, bit 30 = 1 for a read and 0 for a write, bit 29 = fixed flag, bits 28:17 = chunk byte length, bits 16:0 = chunk byte address.
- R2: A request of L bytes becomes chunks of min(remaining, MAX_CHUNK) bytes until nothing remains. A request with L = 0 completes with `done` and no bus activity.
- R3: Once a chunk ends, the next chunk's address is the previous address plus the previous chunk length, modulo 2^17. With the fixed flag set, every chunk reuses the request address.
- R4: During a read, chip select goes high for at least one cycle between the command word, the busy block, each poll word and the data phase, and also between chunks. `spi_sclk` is high only while chip select is low. MOSI changes on the falling edge and MISO is sampled on the rising edge.
- R5: After the command of a read chunk, BUSY_WORDS words are clocked in within one chip-select frame. If bit 0 of the last of them is 1, the data phase follows with no polling.
- R6: If that bit is 0, single-word frames are read until one has bit 0 = 1, for at most POLL_LIMIT frames. A ready word on the final allowed attempt still leads to the data phase.
- R7: If POLL_LIMIT poll words all have bit 0 = 0, the engine delivers ceil(chunk/4) zero words on the read stream, raises `err` in the same cycle as `done`, and issues no further command.
- R8: A write chunk sends its command and then its data words within a single chip-select frame, with no busy phase. The words are taken from the write stream in order.
- R9: A chunk of C bytes moves ceil(C/4) 32-bit words on the wire and on the stream. A partial last word is padded.
- R10: After reset and while idle, chip select is high, `spi_sclk` is low and `req_ready` is high. `req_ready` stays low while a request is in progress, and `done` lasts exactly one cycle.
- R11: Read words appear on `rd_data` in wire order. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fixed | input | 1 | Keep the same address for every chunk |
| req_addr | input | 17 | Start byte address |
| req_len | input | LEN_W | Total byte length |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word offered |
| rd_ready | input | 1 | Read word taken |
| rd_data | output | 32 | Read word |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Poll timeout, valid with done |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to target |
| spi_miso | input | 1 | Serial data from target |

## Verification
The hardest state to reach is the poll timeout. It happens only when a target withholds ready for the full retry budget, and what must be shown there is the zero-fill, the `err` flag and the dropped remaining chunks. The bench target model can be told how many poll frames to withhold ready. It is set both to exactly the limit, where the read must still succeed, and to one beyond it. Meanwhile it counts chip-select frames so that every release between phases is visible at the pins. Chunk splitting, address wrap at the 17-bit boundary and read backpressure are reached by giving the engine a small chunk size and a small poll limit.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int ADDR_W = 17;
  localparam int CLEN_W = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_GAP, S_BUSY, S_POLL, S_RD, S_RD_OUT,
    S_WR_WAIT, S_WR, S_FILL, S_END
  } eng_state_e;

  // Command word: [30] read, [29] fixed, [28:17] length, [16:0] address.
  function automatic logic [31:0] make_cmd(input logic rd, input logic fx,
                                           input logic [CLEN_W-1:0] clen,
                                           input logic [ADDR_W-1:0] addr);
    return {1'b0, rd, fx, clen, addr};
  endfunction

  function automatic logic [31:0] pick_chunk(input logic [31:0] remaining,
                                             input logic [31:0] cap);
    return (remaining > cap) ? cap : remaining;
  endfunction

  function automatic logic [31:0] words_of(input logic [31:0] bytes);
    return (bytes + 32'd3) >> 2;
  endfunction

endpackage

// File: rtl/spi_word_shifter.sv
// Shifts one 32-bit word out and in, MSB first, SPI mode 0, two clocks per bit.
module spi_word_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        done,
  output logic [31:0] rx_word,
  output logic        sclk,
  output logic        mosi
);
  logic [31:0] tx_q, rx_q;
  logic [4:0]  bit_q;
  logic        ph_q, act_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      ph_q   <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !act_q) begin
        tx_q  <= tx_word;
        act_q <= 1'b1;
        ph_q  <= 1'b0;
        bit_q <= '0;
      end else if (act_q) begin
        if (!ph_q) begin
          ph_q <= 1'b1;                    // sclk rises: sample
          rx_q <= {rx_q[30:0], miso};
        end else begin
          ph_q <= 1'b0;                    // sclk falls: next bit out
          tx_q <= {tx_q[30:0], 1'b0};
          if (bit_q == 5'd31) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 5'd1;
          end
        end
      end
    end
  end

  assign sclk    = act_q & ph_q;
  assign mosi    = tx_q[31];
  assign done    = done_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_chunk_ctrl.sv
module spi_chunk_ctrl
  import spi_eng_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MAX_CHUNK  = 4092,
  parameter int BUSY_WORDS = 2,
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_W     = 10,
  parameter int WCNT_W     = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_fixed,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [31:0]        wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [31:0]        rd_data,
  output logic               done,
  output logic               err,
  output logic               cs_n,
  output logic               sh_start,
  output logic [31:0]        sh_tx,
  input  logic               sh_done,
  input  logic [31:0]        sh_rx,
  output logic               cmd_issue,
  output logic [CLEN_W-1:0]  cmd_len,
  output logic               poll_fire,
  output logic [POLL_W-1:0]  poll_cnt
);
  localparam int BCNT_W = (BUSY_WORDS > 1) ? $clog2(BUSY_WORDS) : 1;

  eng_state_e          st_q, gap_nxt_q;
  logic [ADDR_W-1:0]   addr_q, nxt_addr;
  logic [LEN_W-1:0]    rem_q;
  logic                rd_dir_q, fixed_q, err_q, launched_q;
  logic [WCNT_W-1:0]   wleft_q;
  logic [BCNT_W-1:0]   bcnt_q;
  logic [POLL_W-1:0]   pcnt_q;
  logic [31:0]         hold_q;
  logic [CLEN_W-1:0]   clen;
  logic                last_chunk, shifting, last_word;

  assign clen       = CLEN_W'(pick_chunk(32'(rem_q), 32'(MAX_CHUNK)));
  assign last_chunk = (rem_q == LEN_W'(clen));
  assign nxt_addr   = fixed_q ? addr_q : addr_q + ADDR_W'(clen);
  assign last_word  = (wleft_q == WCNT_W'(1));

  always_comb begin
    case (st_q)
      S_CMD, S_BUSY, S_POLL, S_RD, S_WR: shifting = 1'b1;
      default:                           shifting = 1'b0;
    endcase
  end

  always_comb begin
    case (st_q)
      S_CMD, S_BUSY, S_POLL, S_RD, S_RD_OUT, S_WR_WAIT, S_WR: cs_n = 1'b0;
      default:                                                cs_n = 1'b1;
    endcase
  end

  always_comb begin
    case (st_q)
      S_CMD:   sh_tx = make_cmd(rd_dir_q, fixed_q, clen, addr_q);
      S_WR:    sh_tx = hold_q;
      default: sh_tx = '0;
    endcase
  end

  assign sh_start  = shifting && !launched_q;
  assign cmd_issue = sh_start && (st_q == S_CMD);
  assign cmd_len   = clen;
  assign poll_fire = sh_start && (st_q == S_POLL);
  assign poll_cnt  = pcnt_q;
  assign req_ready = (st_q == S_IDLE);
  assign wr_ready  = (st_q == S_WR_WAIT);
  assign rd_valid  = (st_q == S_RD_OUT) || (st_q == S_FILL);
  assign rd_data   = (st_q == S_RD_OUT) ? hold_q : '0;
  assign done      = (st_q == S_END);
  assign err       = (st_q == S_END) && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      gap_nxt_q  <= S_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      rd_dir_q   <= 1'b0;
      fixed_q    <= 1'b0;
      err_q      <= 1'b0;
      launched_q <= 1'b0;
      wleft_q    <= '0;
      bcnt_q     <= '0;
      pcnt_q     <= '0;
      hold_q     <= '0;
    end else begin
      if (sh_start)     launched_q <= 1'b1;
      else if (sh_done) launched_q <= 1'b0;

      case (st_q)
        S_IDLE: if (req_valid) begin
          addr_q   <= req_addr;
          rem_q    <= req_len;
          rd_dir_q <= !req_write;
          fixed_q  <= req_fixed;
          err_q    <= 1'b0;
          st_q     <= (req_len == '0) ? S_END : S_CMD;
        end
        S_CMD: if (sh_done) begin
          wleft_q <= WCNT_W'(words_of(32'(clen)));
          if (rd_dir_q) begin
            bcnt_q    <= '0;
            gap_nxt_q <= S_BUSY;
            st_q      <= S_GAP;
          end else begin
            st_q <= S_WR_WAIT;
          end
        end
        S_GAP: st_q <= gap_nxt_q;
        S_BUSY: if (sh_done) begin
          if (bcnt_q == BCNT_W'(BUSY_WORDS - 1)) begin
            pcnt_q    <= '0;
            gap_nxt_q <= sh_rx[0] ? S_RD : S_POLL;
            st_q      <= S_GAP;
          end else begin
            bcnt_q <= bcnt_q + BCNT_W'(1);
          end
        end
        S_POLL: if (sh_done) begin
          pcnt_q <= pcnt_q + POLL_W'(1);
          if (sh_rx[0]) begin
            gap_nxt_q <= S_RD;
            st_q      <= S_GAP;
          end else if (pcnt_q == POLL_W'(POLL_LIMIT - 1)) begin
            st_q <= S_FILL;
          end else begin
            gap_nxt_q <= S_POLL;
            st_q      <= S_GAP;
          end
        end
        S_RD: if (sh_done) begin
          hold_q <= sh_rx;
          st_q   <= S_RD_OUT;
        end
        S_RD_OUT: if (rd_ready) begin
          wleft_q <= wleft_q - WCNT_W'(1);
          if (!last_word) begin
            st_q <= S_RD;
          end else begin
            rem_q  <= rem_q - LEN_W'(clen);
            addr_q <= nxt_addr;
            if (last_chunk) st_q <= S_END;
            else begin
              gap_nxt_q <= S_CMD;
              st_q      <= S_GAP;
            end
          end
        end
        S_WR_WAIT: if (wr_valid) begin
          hold_q <= wr_data;
          st_q   <= S_WR;
        end
        S_WR: if (sh_done) begin
          wleft_q <= wleft_q - WCNT_W'(1);
          if (!last_word) begin
            st_q <= S_WR_WAIT;
          end else begin
            rem_q  <= rem_q - LEN_W'(clen);
            addr_q <= nxt_addr;
            if (last_chunk) st_q <= S_END;
            else begin
              gap_nxt_q <= S_CMD;
              st_q      <= S_GAP;
            end
          end
        end
        S_FILL: if (rd_ready) begin
          wleft_q <= wleft_q - WCNT_W'(1);
          if (last_word) begin
            err_q <= 1'b1;
            st_q  <= S_END;
          end
        end
        S_END:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_chunk_engine.sv
module spi_chunk_engine
  import spi_eng_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MAX_CHUNK  = 4092,  // multiple of 4, at most 4095
  parameter int BUSY_WORDS = 2,
  parameter int POLL_LIMIT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_fixed,
  input  logic [16:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [31:0]      wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_data,
  output logic             done,
  output logic             err,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int WCNT_W = $clog2(MAX_CHUNK / 4 + 2);

  logic              sh_start, sh_done;
  logic [31:0]       sh_tx, sh_rx;
  logic              cmd_issue, poll_fire;
  logic [CLEN_W-1:0] cmd_len;
  logic [POLL_W-1:0] poll_cnt;

  spi_chunk_ctrl #(
    .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK), .BUSY_WORDS(BUSY_WORDS),
    .POLL_LIMIT(POLL_LIMIT), .POLL_W(POLL_W), .WCNT_W(WCNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_fixed(req_fixed), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err), .cs_n(spi_cs_n),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
    .cmd_issue(cmd_issue), .cmd_len(cmd_len),
    .poll_fire(poll_fire), .poll_cnt(poll_cnt)
  );

  spi_word_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_word(sh_tx),
    .miso(spi_miso), .done(sh_done), .rx_word(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );
endmodule

// File: rtl/spi_chunk_engine_chk.sv
module spi_chunk_engine_chk #(
  parameter int MAX_CHUNK  = 4092,
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_W     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [31:0]       rd_data,
  input logic              cmd_issue,
  input logic [11:0]       cmd_len,
  input logic              poll_fire,
  input logic [POLL_W-1:0] poll_cnt
);
  assert_idle_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  assert_sclk_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_chunk_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> (cmd_len != 12'd0 && 32'(cmd_len) <= MAX_CHUNK));

  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fire |-> 32'(poll_cnt) < POLL_LIMIT);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind spi_chunk_engine spi_chunk_engine_chk #(
  .MAX_CHUNK(MAX_CHUNK), .POLL_LIMIT(POLL_LIMIT), .POLL_W(POLL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .req_ready(req_ready), .done(done), .err(err),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .cmd_issue(cmd_issue), .cmd_len(cmd_len),
  .poll_fire(poll_fire), .poll_cnt(poll_cnt)
);

// File: tb/spi_chunk_engine_test.sv
`timescale 1ns/1ps
module spi_chunk_engine_test;
  localparam int CHUNK = 16;
  localparam int LIM   = 5;
  localparam int BW    = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fixed = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic wr_valid = 1'b1, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic req_ready, wr_ready, rd_valid, done, err;
  logic [31:0] rd_data;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  spi_chunk_engine #(.LEN_W(16), .MAX_CHUNK(CHUNK), .BUSY_WORDS(BW),
                     .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fixed(req_fixed), .req_addr(req_addr),
    .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .done(done), .err(err), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit wd_fired = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    logic [31:0] m = a & 32'h1FFFF;
    return 32'hC300_0000 ^ (m * 32'h0001_0103);
  endfunction

  function automatic logic [31:0] wrw(input int v, input int k);
    return 32'hB000_0000 | (32'(v) << 16) | 32'(k);
  endfunction

  // ---------------- target model ----------------
  int s_state = 0;       // 0 cmd, 1 write data, 2 busy block, 3 poll, 4 read data
  int s_bits = 0, s_need = 0, s_pcnt = 0, s_widx = 0, s_wleft = 0;
  logic [16:0] s_addr = '0;
  logic s_fx = 1'b0;
  logic [31:0] s_rx = '0, s_tx = '0;
  int cs_falls = 0, cmd_n = 0, wr_n = 0;
  logic [31:0] got_cmd [0:15];
  logic [31:0] got_wr  [0:31];

  function automatic logic [31:0] slave_word();
    case (s_state)
      2: return (s_widx == BW - 1 && s_need == 0) ? 32'h5A5A_0001 : 32'h5A5A_0000;
      3: return (s_pcnt + 1 == s_need) ? 32'h0000_0003 : 32'h0000_0002;
      4: return pat(32'(s_addr) + (s_fx ? 32'd0 : 32'(4 * s_widx)));
      default: return 32'h0;
    endcase
  endfunction

  task automatic slave_word_done();
    case (s_state)
      0: begin
        if (cmd_n < 16) got_cmd[cmd_n] = s_rx;
        cmd_n++;
        s_addr  = s_rx[16:0];
        s_fx    = s_rx[29];
        s_wleft = (int'(s_rx[28:17]) + 3) / 4;
        s_widx  = 0;
        s_pcnt  = 0;
        s_state = s_rx[30] ? 2 : 1;
      end
      1: begin
        if (wr_n < 32) got_wr[wr_n] = s_rx;
        wr_n++;
        s_wleft--;
        if (s_wleft == 0) s_state = 0;
      end
      2: begin
        if (s_widx == BW - 1) begin
          s_widx  = 0;
          s_state = (s_need == 0) ? 4 : 3;
        end else s_widx++;
      end
      3: begin
        if (s_pcnt + 1 == s_need) begin s_widx = 0; s_state = 4; end
        s_pcnt++;
      end
      4: begin
        s_widx++;
        if (s_widx == s_wleft) s_state = 0;
      end
      default: s_state = 0;
    endcase
  endtask

  always @(negedge spi_cs_n) begin
    cs_falls++;
    s_bits = 0;
    s_tx = slave_word();
    spi_miso = s_tx[31];
  end

  always @(posedge spi_sclk) begin
    s_rx = {s_rx[30:0], spi_mosi};
    s_bits++;
    if (s_bits == 32) begin
      s_bits = 0;
      slave_word_done();
    end
  end

  always @(negedge spi_sclk) begin
    if (s_bits == 0) s_tx = slave_word();
    else s_tx = {s_tx[30:0], 1'b0};
    spi_miso = s_tx[31];
  end

  // ---------------- watchdog ----------------
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_fired) begin
      wd_fired = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- vectors ----------------
  typedef struct packed {
    logic        wr;
    logic        fx;
    logic [16:0] addr;
    logic [15:0] len;
    logic [7:0]  polls;
    logic        bp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 17'h00100, 16'd8,  8'd0, 1'b0},  // R5 simple read
    '{1'b0, 1'b0, 17'h00200, 16'd40, 8'd0, 1'b1},  // R2 three chunks, R11 backpressure
    '{1'b1, 1'b0, 17'h00300, 16'd20, 8'd0, 1'b0},  // R8 write two chunks
    '{1'b1, 1'b1, 17'h00400, 16'd36, 8'd0, 1'b0},  // R3 fixed write
    '{1'b0, 1'b1, 17'h000A0, 16'd24, 8'd2, 1'b0},  // R6 polls, fixed read
    '{1'b0, 1'b0, 17'h1FFF8, 16'd24, 8'd0, 1'b0},  // R3 address wrap
    '{1'b0, 1'b0, 17'h00010, 16'd6,  8'd5, 1'b0},  // R6 ready on last attempt, R9 pad
    '{1'b0, 1'b0, 17'h00600, 16'd20, 8'd6, 1'b0},  // R7 timeout
    '{1'b1, 1'b0, 17'h00501, 16'd3,  8'd0, 1'b0}   // R9 partial write word
  };

  logic [31:0] exp_cmd [0:15];
  logic [31:0] exp_dat [0:31];
  logic [31:0] got_rd  [0:31];

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cs_n after reset", 32'(spi_cs_n), 32'd1);
    chk("R10 sclk after reset", 32'(spi_sclk), 32'd0);
    chk("R10 req_ready after reset", 32'(req_ready), 32'd1);
    chk("R10 done after reset", 32'(done), 32'd0);
    chk("R10 rd_valid after reset", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle cs_n", 32'(spi_cs_n), 32'd1);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int rem, ne, nd, ncs, tick, k, rd_n;
      logic [16:0] a;
      bit hs, seen, err_seen, tmo;
      string dtag, ctag;
      t = VECS[v];
      rem = int'(t.len); a = t.addr; ne = 0; nd = 0; ncs = 0;
      tmo = (!t.wr) && (int'(t.polls) > LIM);
      while (rem > 0) begin
        int c, nw;
        c  = (rem > CHUNK) ? CHUNK : rem;
        nw = (c + 3) / 4;
        exp_cmd[ne] = {1'b0, !t.wr, t.fx, 12'(c), a};
        ne++;
        if (t.wr) begin
          for (int i = 0; i < nw; i++) begin exp_dat[nd] = wrw(v, nd); nd++; end
          ncs += 1;
        end else if (tmo) begin
          for (int i = 0; i < nw; i++) begin exp_dat[nd] = 32'h0; nd++; end
          ncs += 2 + LIM;
          break;
        end else begin
          for (int i = 0; i < nw; i++) begin
            exp_dat[nd] = pat(32'(a) + (t.fx ? 32'd0 : 32'(4 * i)));
            nd++;
          end
          ncs += 3 + int'(t.polls);
        end
        rem -= c;
        if (!t.fx) a = a + 17'(c);
      end
      dtag = t.wr ? "R8 write word" : (tmo ? "R7 zero fill" : "R11 read word");
      ctag = t.wr ? "R8 frames" : (tmo ? "R7 frames" :
             ((t.polls == 0) ? "R5 frames" : "R6 frames"));

      s_state = 0; s_need = int'(t.polls); cmd_n = 0; wr_n = 0; cs_falls = 0;
      rd_n = 0; k = 0; hs = 1'b0; seen = 1'b0; err_seen = 1'b0; tick = 0;

      @(negedge clk);
      req_valid = 1'b1; req_write = t.wr; req_fixed = t.fx;
      req_addr = t.addr; req_len = t.len;
      wr_data = wrw(v, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 req_ready busy", 32'(req_ready), 32'd0);

      while (!seen && tick < 20000) begin
        @(negedge clk);
        tick++;
        if (hs) k++;
        wr_data = wrw(v, k);
        rd_ready = t.bp ? (tick % 3 != 0) : 1'b1;
        if (rd_valid && rd_ready) begin
          if (rd_n < 32) got_rd[rd_n] = rd_data;
          rd_n++;
        end
        hs = wr_ready;
        if (done) begin seen = 1'b1; err_seen = err; end
      end
      chk("R10 done seen", 32'(seen), 32'd1);
      @(negedge clk);
      chk("R10 done one cycle", 32'(done), 32'd0);

      chk("R2 chunk count", 32'(cmd_n), 32'(ne));
      for (int i = 0; i < ne && i < cmd_n; i++)
        chk("R1 R3 command word", got_cmd[i], exp_cmd[i]);
      if (t.wr) begin
        chk("R9 write word count", 32'(wr_n), 32'(nd));
        for (int i = 0; i < nd && i < wr_n; i++) chk(dtag, got_wr[i], exp_dat[i]);
      end else begin
        chk("R9 read word count", 32'(rd_n), 32'(nd));
        for (int i = 0; i < nd && i < rd_n; i++) chk(dtag, got_rd[i], exp_dat[i]);
      end
      chk(ctag, 32'(cs_falls), 32'(ncs));
      chk("R7 err flag", 32'(err_seen), 32'(tmo));
    end

    // R2 zero-length request
    begin
      int tick;
      bit seen;
      cs_falls = 0; cmd_n = 0; seen = 1'b0; tick = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_fixed = 1'b0;
      req_addr = 17'h00700; req_len = 16'd0;
      @(negedge clk);
      req_valid = 1'b0;
      while (!seen && tick < 100) begin
        if (done) seen = 1'b1;
        @(negedge clk);
        tick++;
      end
      chk("R2 zero length done", 32'(seen), 32'd1);
      chk("R2 zero length no frames", 32'(cs_falls), 32'd0);
      chk("R10 idle after zero length", 32'(req_ready), 32'd1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule